// File: doc/BRIEF.md
# Collision-Free Stochastic OR16 Multiply-Accumulate Unit

This unit forms an approximate dot product of sixteen unsigned 8-bit activations with sixteen unsigned 8-bit weights, using stochastic bit-streams. Each cycle of a pass, two shared random samples are drawn, one on the activation axis and one on the weight axis. Every row turns these samples into its own stochastic operand bits. The row ANDs its two bits into a product bit, and the sixteen product bits are ORed into one bit, which a counter sums over the pass.

The pair of samples is a point in a square. That square is cut into a 4×4 grid of disjoint cells, and each row owns exactly one cell. A row can only produce a 1 when the point lies inside its own cell, so in any cycle at most one product bit is high. The OR therefore never merges two ones, and the final count equals the sum of the row contributions with no saturation loss.

A pass starts with a one-cycle `start` request. `len_sel` chooses a short stream (64 cycles) or a long one (256 cycles). The operands are held steady by the user for the whole pass. When the pass ends, a one-cycle `done` marks a valid `count`.

Top module: `or16_sc_mac`

## Requirements
- R1: After reset, `count` is 0 and `done` is 0.
- R2: Row r (activation byte `act[8r+7:8r]`, weight byte `wgt[8r+7:8r]`) yields a product bit of 1 in a cycle exactly when all four of these hold: bits [7:6] of the activation sample equal r[3:2]; bits [7:6] of the weight sample equal r[1:0]; bits [5:0] of the activation sample are below `act_r>>2`; bits [5:0] of the weight sample are below `wgt_r>>2`. As a result, operands below 4 never contribute.
- R3: In every cycle, no more than one row product bit is 1.
- R4: The activation sample comes from an 8-bit register that shifts left once per pass cycle, taking into bit 0 the XOR of its bits 7, 5, 4 and 3; its seed is 0x5A. The weight sample uses the same scheme with bits 7, 3, 2 and 1 and seed 0xC3. Both registers load their seeds on reset and on every accepted start, and they never hold zero.
- R5: At the end of a pass, `count` equals the number of pass cycles in which the OR of the row products was 1. The pass lasts 64 cycles when `len_sel` is 0 and 256 cycles when it is 1.
- R6: `done` is high for exactly one cycle, after clock edge L following the edge that accepted `start`, and it is low at all other times.
- R7: While a pass runs, `start` is ignored and a changed `len_sel` has no effect. The pass keeps its length and its count.
- R8: An accepted start clears `count` to 0 at the accepting edge. After `done`, `count` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pass when idle |
| len_sel | input | 1 | Stream length: 0 gives 64 cycles, 1 gives 256 |
| act | input | 128 | Sixteen unsigned activation bytes, row r in bits [8r+7:8r] |
| wgt | input | 128 | Sixteen unsigned weight bytes, row r in bits [8r+7:8r] |
| count | output | 10 | Number of cycles in which the OR output was 1 |
| done | output | 1 | One-cycle pulse when the pass count is final |

## Verification
The dense case, with every operand at 255, makes every row eligible at once. A design that let rows overlap would lose counts to OR saturation and fall short of the independently modelled total. A single active row and an all-small-operand pass check the cell decode and the shift-by-two threshold: a wrong cell mapping or an off-by-one comparison moves the count, and operands below 4 must yield zero. A start pulse with a flipped length select in the middle of a pass checks that the pass is not restarted or re-lengthened. A design that honoured that pulse would clear the count, or end the pass at the wrong cycle. Each pass also checks the clear at the start edge, the exact cycle of `done`, and the hold of `count` afterwards, for both stream lengths.

// File: rtl/sc_mac_pkg.sv
package sc_mac_pkg;
    localparam int ROWS_DEF     = 16;
    localparam int DW_DEF       = 8;
    localparam int CW_DEF       = 10;
    localparam int LEN_FAST_DEF = 64;
    localparam int LEN_FULL_DEF = 256;
    localparam logic [7:0] SEED_A_DEF = 8'h5A;
    localparam logic [7:0] SEED_W_DEF = 8'hC3;
    localparam logic [7:0] TAPS_A_DEF = 8'hB8;
    localparam logic [7:0] TAPS_W_DEF = 8'h8E;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] TAPS = 8'hB8,
    parameter logic [DW-1:0] SEED = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [DW-1:0] sample
);
    logic [DW-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load)
            state_d = SEED;
        else if (step)
            state_d = {state_q[DW-2:0], ^(state_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign sample = state_q;

    // R4: the generator never locks up in the all-zero state
    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/sc_row_cell.sv
module sc_row_cell #(
    parameter int DW  = 8,
    parameter int PB  = 2,
    parameter int ROW = 0
) (
    input  logic [DW-1:0] samp_a,
    input  logic [DW-1:0] samp_w,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_w,
    output logic          prod
);
    localparam int LW = DW - PB;
    localparam logic [2*PB-1:0] RID    = ROW[2*PB-1:0];
    localparam logic [PB-1:0]   CELL_A = RID[2*PB-1:PB];
    localparam logic [PB-1:0]   CELL_W = RID[PB-1:0];

    logic in_cell_a, in_cell_w, bit_a, bit_w;

    always_comb begin
        in_cell_a = (samp_a[DW-1 -: PB] == CELL_A);
        in_cell_w = (samp_w[DW-1 -: PB] == CELL_W);
        bit_a     = in_cell_a && (samp_a[LW-1:0] < opnd_a[DW-1:PB]);
        bit_w     = in_cell_w && (samp_w[LW-1:0] < opnd_w[DW-1:PB]);
        prod      = bit_a & bit_w;
    end
endmodule

// File: rtl/sc_stream_ctrl.sv
module sc_stream_ctrl #(
    parameter int CW       = 10,
    parameter int LEN_FAST = 64,
    parameter int LEN_FULL = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          len_sel,
    input  logic          or_bit,
    output logic          gen_load,
    output logic          gen_step,
    output logic [CW-1:0] count,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          len;
        logic [CW-1:0] cnt;
        logic [CW-1:0] idx;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  last;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        gen_load = 1'b0;
        gen_step = 1'b0;
        last     = (ctl_q.idx == (ctl_q.len ? CW'(LEN_FULL - 1) : CW'(LEN_FAST - 1)));
        if (!ctl_q.busy) begin
            if (start) begin
                ctl_d.busy = 1'b1;
                ctl_d.len  = len_sel;
                ctl_d.cnt  = '0;
                ctl_d.idx  = '0;
                gen_load   = 1'b1;
            end
        end else begin
            gen_step  = 1'b1;
            ctl_d.cnt = ctl_q.cnt + CW'(or_bit);
            ctl_d.idx = ctl_q.idx + 1'b1;
            if (last) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign count = ctl_q.cnt;
    assign done  = ctl_q.done;

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: the count cannot exceed the longest stream
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(LEN_FULL));
    // R7: a start during a pass does not end the pass
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && !last && start) |=> ctl_q.busy);
    // R8: an accepted start clears the count
    p_count_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.busy && start) |=> (count == '0));
endmodule

// File: rtl/or16_sc_mac.sv
module or16_sc_mac
    import sc_mac_pkg::*;
#(
    parameter int ROWS     = ROWS_DEF,
    parameter int DW       = DW_DEF,
    parameter int CW       = CW_DEF,
    parameter int LEN_FAST = LEN_FAST_DEF,
    parameter int LEN_FULL = LEN_FULL_DEF,
    parameter logic [DW-1:0] SEED_A = SEED_A_DEF,
    parameter logic [DW-1:0] SEED_W = SEED_W_DEF,
    parameter logic [DW-1:0] TAPS_A = TAPS_A_DEF,
    parameter logic [DW-1:0] TAPS_W = TAPS_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 len_sel,
    input  logic [ROWS*DW-1:0]   act,
    input  logic [ROWS*DW-1:0]   wgt,
    output logic [CW-1:0]        count,
    output logic                 done
);
    localparam int PB = $clog2(ROWS) / 2;

    logic [DW-1:0]   samp_a, samp_w;
    logic [ROWS-1:0] prods;
    logic            or_bit, gen_load, gen_step;

    sc_lfsr #(.DW(DW), .TAPS(TAPS_A), .SEED(SEED_A)) u_gen_a (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step), .sample(samp_a));

    sc_lfsr #(.DW(DW), .TAPS(TAPS_W), .SEED(SEED_W)) u_gen_w (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step), .sample(samp_w));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        sc_row_cell #(.DW(DW), .PB(PB), .ROW(r)) u_cell (
            .samp_a(samp_a),
            .samp_w(samp_w),
            .opnd_a(act[r*DW +: DW]),
            .opnd_w(wgt[r*DW +: DW]),
            .prod  (prods[r]));
    end

    assign or_bit = |prods;

    sc_stream_ctrl #(.CW(CW), .LEN_FAST(LEN_FAST), .LEN_FULL(LEN_FULL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel), .or_bit(or_bit),
        .gen_load(gen_load), .gen_step(gen_step), .count(count), .done(done));

    // R3: disjoint cells mean the OR tree never sees two ones
    p_one_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prods));
endmodule

// File: tb/tb_or16_sc_mac.sv
module tb_or16_sc_mac;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         len_sel = 1'b0;
    logic [127:0] act = '0;
    logic [127:0] wgt = '0;
    logic [9:0]   count;
    logic         done;
    int           n_chk = 0;
    int           n_err = 0;

    always #4 clk = ~clk;

    or16_sc_mac dut (.clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
                     .act(act), .wgt(wgt), .count(count), .done(done));

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // R2, R4, R5: reference count from the stated generator and cell rules
    function automatic int model(input logic [127:0] a, input logic [127:0] w, input int len);
        logic [7:0] sa = 8'h5A;
        logic [7:0] sw = 8'hC3;
        int c = 0;
        for (int k = 0; k < len; k++) begin
            bit any = 0;
            for (int r = 0; r < 16; r++) begin
                logic [3:0] rr = 4'(r);
                if (sa[7:6] == rr[3:2] && sw[7:6] == rr[1:0] &&
                    sa[5:0] < a[8*r+2 +: 6] && sw[5:0] < w[8*r+2 +: 6])
                    any = 1;
            end
            if (any) c++;
            sa = {sa[6:0], sa[7] ^ sa[5] ^ sa[4] ^ sa[3]};
            sw = {sw[6:0], sw[7] ^ sw[3] ^ sw[2] ^ sw[1]};
        end
        return c;
    endfunction

    // one pass with cycle-exact checks; poke injects a start mid-pass (R7)
    task automatic run_pass(input bit ls, input string tag, input bit poke);
        int len = ls ? 256 : 64;
        int expv = model(act, wgt, len);
        @(negedge clk);
        start = 1'b1; len_sel = ls;
        @(negedge clk);
        start = 1'b0;
        chk(count == 0, {"R8 clear ", tag}, count, 0);
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (k < len) chk(done == 1'b0, {"R6 early ", tag}, done, 0);
            else begin
                chk(done == 1'b1, {"R6 done ", tag}, done, 1);
                chk(count == 10'(expv), {"R5 count ", tag}, count, expv);
            end
            start = 1'b0;
            if (poke && k == 10) begin start = 1'b1; len_sel = ~ls; end
        end
        @(negedge clk);
        chk(done == 1'b0, {"R6 pulse ", tag}, done, 0);
        chk(count == 10'(expv), {"R8 hold ", tag}, count, expv);
        repeat (3) @(negedge clk);
        chk(count == 10'(expv), {"R8 hold late ", tag}, count, expv);
        len_sel = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(count == 0, "R1 count", count, 0);
        chk(done == 0, "R1 done", done, 0);
    endtask

    task automatic t_mixed;
        for (int r = 0; r < 16; r++) begin
            act[8*r +: 8] = 8'(r * 37 + 11);
            wgt[8*r +: 8] = 8'(200 - r * 13);
        end
        run_pass(1'b1, "R2 R4 mixed long", 1'b0);
        run_pass(1'b0, "R2 R4 mixed short", 1'b0);
    endtask

    task automatic t_dense;
        act = '1; wgt = '1;
        run_pass(1'b1, "R3 R5 dense", 1'b0);
        chk(count > 10'd200, "R3 dense no saturation", count, 201);
    endtask

    task automatic t_small;
        for (int r = 0; r < 16; r++) begin
            act[8*r +: 8] = 8'(r % 4);
            wgt[8*r +: 8] = 8'd3;
        end
        run_pass(1'b1, "R2 small operands", 1'b0);
        chk(count == 0, "R2 below four", count, 0);
    endtask

    task automatic t_single_row;
        act = '0; wgt = '0;
        act[8*9 +: 8] = 8'd255;
        wgt[8*9 +: 8] = 8'd255;
        run_pass(1'b1, "R2 row9 only", 1'b0);
    endtask

    task automatic t_ignore_start;
        for (int r = 0; r < 16; r++) begin
            act[8*r +: 8] = 8'(90 + r * 9);
            wgt[8*r +: 8] = 8'(250 - r * 5);
        end
        run_pass(1'b0, "R7 start while busy", 1'b1);
        run_pass(1'b1, "R7 start while busy long", 1'b1);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mixed();
        t_dense();
        t_small();
        t_single_row();
        t_ignore_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule